// File: doc/BRIEF.md
# Cache Maintenance Command Queue Frontend

This block is the register face of an outer-cache maintenance engine that several bus masters share. A master claims the command registers by writing the mode word. It then fills in the start address, byte count, address mask and way selection it needs. Reading the set-complete register launches the command if the claim held. When two masters race, only the first claimant's writes land. The loser learns from its own set-complete flags that it must rewrite the whole set.

An accepted command goes to a behavioural executor that spends one cycle per cache line of the range, or one cycle per set for whole-cache or way scope. When the executor finishes it raises a sticky finished flag, cleared by writing 1. A separate primitive register takes buffer-drain and prefetch-buffer-flush codes. A read of that register is held back until the drain has ended.

Accesses arrive one per cycle on a shared request port that carries the master number. A read answers on a separate response strobe. The request port holds ready low while a read is outstanding.

Top module: `cmq_frontend`

## Requirements
- R1: After reset the status register (offset 0x260), the mode register (0x248) and every master's set-complete flags (0x25C) read as zero.
- R2: The first master to write the mode register while no command runs and no master holds the registers becomes holder. Mode, start address (0x24C), size (0x250), address mask (0x254) and way (0x258) writes from any other master are dropped and set that master's reject flag (set-complete bit 0).
- R3: A mode write while a command executes changes nothing and sets the writer's busy-reject flag (set-complete bit 1).
- R4: A set-complete read by the holder returns 0, launches the command and releases the registers so another master can claim them.
- R5: With scope field (mode bits 18:17) equal to 0, status bit 0 reads 1 for exactly max(1, ceil(((start mod LINE) + size) / LINE)) cycles, beginning the cycle after launch.
- R6: With scope 1 (whole cache) or scope 2 (selected ways), status bit 0 reads 1 for exactly NSETS cycles after launch.
- R7: When mode bit 15 was set at launch, status bit 2 becomes 1 one cycle after bit 0 falls. Without bit 15 it stays 0.
- R8: Writing status with bit 2 set clears bit 2. Writing status with bit 2 clear leaves it; bit 1 clears the same way.
- R9: Scope value 3 starts no execution and sets status bit 1.
- R10: Writing code 8 or 9 to the primitive register (0x244) starts a drain of DRAIN_CYCLES cycles. A read of that register answers exactly DRAIN_CYCLES+1 cycles after the write and returns the last accepted code. Other codes are ignored.
- R11: Reads of any other register answer on the cycle after acceptance; the set-complete read returns the reader's own flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_id | input | IDW | Number of the requesting master |
| req_addr | input | AW | Byte offset in the operation window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume at most one access per cycle and that no new request is driven while a read is unanswered. The bench issues one access at a time and waits for each response before the next. The assertions also assume a command can launch only while the executor is idle, which holds because claims are refused while it runs. Timing checks compare each status read with the launch cycle recorded by the bench. Drain checks use the recorded write cycle in the same way.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

    localparam logic [11:0] OFS_PRIM  = 12'h244;
    localparam logic [11:0] OFS_MODE  = 12'h248;
    localparam logic [11:0] OFS_START = 12'h24C;
    localparam logic [11:0] OFS_SIZE  = 12'h250;
    localparam logic [11:0] OFS_AMASK = 12'h254;
    localparam logic [11:0] OFS_WAYS  = 12'h258;
    localparam logic [11:0] OFS_SETC  = 12'h25C;
    localparam logic [11:0] OFS_STAT  = 12'h260;

    localparam logic [3:0] PRIM_DRAIN   = 4'h8;
    localparam logic [3:0] PRIM_PFFLUSH = 4'h9;

    typedef enum logic [1:0] {
        SCOPE_RANGE = 2'd0,
        SCOPE_ALL   = 2'd1,
        SCOPE_WAYS  = 2'd2,
        SCOPE_RSV   = 2'd3
    } scope_e;

    typedef struct packed {
        scope_e scope;
        logic   notify;
    } exec_req_t;

    function automatic exec_req_t decode_mode(input logic [31:0] w);
        exec_req_t r;
        r.scope  = scope_e'(w[18:17]);
        r.notify = w[15];
        return r;
    endfunction

    function automatic logic [31:0] range_lines(input logic [31:0] start,
                                                input logic [31:0] size,
                                                input int          shift);
        logic [32:0] lmask;
        logic [32:0] total;
        logic [32:0] n;
        lmask = (33'd1 << shift) - 33'd1;
        total = ({1'b0, start} & lmask) + {1'b0, size} + lmask;
        n     = total >> shift;
        return (n == 33'd0) ? 32'd1 : n[31:0];
    endfunction

endpackage

// File: rtl/cmq_owner_arb.sv
module cmq_owner_arb #(
    parameter int NM  = 4,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_wr,
    input  logic           reg_wr,
    input  logic [IDW-1:0] wr_id,
    input  logic           sc_rd,
    input  logic [IDW-1:0] sc_id,
    input  logic           exec_busy,
    output logic           mode_take,
    output logic           reg_take,
    output logic           launch,
    output logic [NM-1:0]  fe,
    output logic [NM-1:0]  oe
);
    logic           owner_vld;
    logic [IDW-1:0] owner_id;
    logic           wr_is_owner;
    logic           sc_is_owner;

    assign wr_is_owner = owner_vld && (owner_id == wr_id);
    assign sc_is_owner = owner_vld && (owner_id == sc_id);
    assign mode_take   = mode_wr && !exec_busy && (!owner_vld || wr_is_owner);
    assign reg_take    = reg_wr && !exec_busy && wr_is_owner;
    assign launch      = sc_rd && sc_is_owner && !fe[sc_id] && !oe[sc_id];

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_vld <= 1'b0;
            owner_id  <= '0;
            fe        <= '0;
            oe        <= '0;
        end else begin
            if (mode_wr) begin
                if (exec_busy) begin
                    fe[wr_id] <= 1'b1;
                end else if (mode_take) begin
                    owner_vld <= 1'b1;
                    owner_id  <= wr_id;
                    fe[wr_id] <= 1'b0;
                    oe[wr_id] <= 1'b0;
                end else begin
                    oe[wr_id] <= 1'b1;
                end
            end
            if (reg_wr && !reg_take) begin
                oe[wr_id] <= 1'b1;
            end
            if (sc_rd && sc_is_owner) begin
                owner_vld <= 1'b0;
            end
        end
    end

    // R2
    owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
        owner_vld && !sc_rd |=> owner_vld && (owner_id == $past(owner_id)));

    // R2
    intruder_oe_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr && !exec_busy && owner_vld && (owner_id != wr_id) |=> oe[$past(wr_id)]);

    // R3
    busy_fe_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr && exec_busy |=> fe[$past(wr_id)]);

endmodule

// File: rtl/cmq_exec.sv
module cmq_exec
    import cmq_pkg::*;
#(
    parameter int LINE_SHIFT = 7,
    parameter int NSETS      = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        launch,
    input  exec_req_t   req,
    input  logic [31:0] start,
    input  logic [31:0] size,
    output logic        busy,
    output logic        done_ntf,
    output logic        bad_scope
);
    logic [31:0] cnt;
    logic [31:0] lines;
    logic        ntf_q;
    logic        done;

    always_comb begin
        case (req.scope)
            SCOPE_RANGE: lines = range_lines(start, size, LINE_SHIFT);
            SCOPE_ALL,
            SCOPE_WAYS:  lines = 32'(NSETS);
            default:     lines = 32'd0;
        endcase
    end

    assign bad_scope = launch && (req.scope == SCOPE_RSV);
    assign done_ntf  = done && ntf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            ntf_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch && !bad_scope) begin
                busy  <= 1'b1;
                cnt   <= lines;
                ntf_q <= req.notify;
            end else if (busy) begin
                cnt <= cnt - 32'd1;
                if (cnt == 32'd1) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        launch && !bad_scope |=> busy);

    // R9
    bad_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bad_scope && !busy |=> !busy);

    // R7
    done_edge_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

endmodule

// File: rtl/cmq_drain.sv
module cmq_drain
    import cmq_pkg::*;
#(
    parameter int DRAIN_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prim_wr,
    input  logic [3:0] code,
    output logic       busy,
    output logic [3:0] last_code
);
    localparam int CW = $clog2(DRAIN_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          code_ok;

    assign code_ok = (code == PRIM_DRAIN) || (code == PRIM_PFFLUSH);
    assign busy    = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            last_code <= '0;
        end else if (prim_wr && code_ok) begin
            cnt       <= CW'(DRAIN_CYCLES);
            last_code <= code;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R10
    drain_start_chk: assert property (@(posedge clk) disable iff (rst)
        prim_wr && code_ok |=> busy);

    // R10
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        prim_wr && !code_ok |=> $stable(last_code));

endmodule

// File: rtl/cmq_frontend.sv
module cmq_frontend
    import cmq_pkg::*;
#(
    parameter int NM           = 4,
    parameter int IDW          = (NM > 1) ? $clog2(NM) : 1,
    parameter int AW           = 12,
    parameter int LINE_SHIFT   = 7,
    parameter int NSETS        = 16,
    parameter int DRAIN_CYCLES = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [IDW-1:0] req_id,
    input  logic [AW-1:0]  req_addr,
    input  logic [31:0]    req_wdata,
    output logic           req_ready,
    output logic           rsp_valid,
    output logic [31:0]    rsp_rdata
);
    logic           rd_pend;
    logic [IDW-1:0] rd_id;
    logic [11:0]    rd_addr;
    logic [11:0]    wa;
    logic           wr, rd_acc, rd_fire;
    logic           mode_wr, reg_wr, stat_wr, prim_wr, sc_rd;
    logic           mode_take, reg_take, launch;
    logic [NM-1:0]  fe, oe;
    logic [31:0]    mode_q, start_q, size_q, amask_q, ways_q;
    logic           ef, est;
    logic           ex_busy, done_ntf, bad_scope;
    logic           dr_busy;
    logic [3:0]     dr_code;
    logic [31:0]    rd_val;

    assign wa        = 12'(req_addr);
    assign req_ready = !rd_pend;
    assign wr        = req_valid && req_ready && req_write;
    assign rd_acc    = req_valid && req_ready && !req_write;
    assign rd_fire   = rd_pend && !((rd_addr == OFS_PRIM) && dr_busy);
    assign sc_rd     = rd_fire && (rd_addr == OFS_SETC);
    assign mode_wr   = wr && (wa == OFS_MODE);
    assign reg_wr    = wr && ((wa == OFS_START) || (wa == OFS_SIZE) ||
                              (wa == OFS_AMASK) || (wa == OFS_WAYS));
    assign stat_wr   = wr && (wa == OFS_STAT);
    assign prim_wr   = wr && (wa == OFS_PRIM);

    cmq_owner_arb #(.NM(NM), .IDW(IDW)) u_arb (
        .clk(clk), .rst(rst),
        .mode_wr(mode_wr), .reg_wr(reg_wr), .wr_id(req_id),
        .sc_rd(sc_rd), .sc_id(rd_id), .exec_busy(ex_busy),
        .mode_take(mode_take), .reg_take(reg_take), .launch(launch),
        .fe(fe), .oe(oe)
    );

    cmq_exec #(.LINE_SHIFT(LINE_SHIFT), .NSETS(NSETS)) u_exec (
        .clk(clk), .rst(rst), .launch(launch),
        .req(decode_mode(mode_q)), .start(start_q), .size(size_q),
        .busy(ex_busy), .done_ntf(done_ntf), .bad_scope(bad_scope)
    );

    cmq_drain #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_drain (
        .clk(clk), .rst(rst), .prim_wr(prim_wr), .code(req_wdata[3:0]),
        .busy(dr_busy), .last_code(dr_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            start_q <= '0;
            size_q  <= '0;
            amask_q <= '0;
            ways_q  <= '0;
        end else begin
            if (mode_take) mode_q <= req_wdata;
            if (reg_take) begin
                case (wa)
                    OFS_START: start_q <= req_wdata;
                    OFS_SIZE:  size_q  <= req_wdata;
                    OFS_AMASK: amask_q <= req_wdata;
                    default:   ways_q  <= req_wdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ef  <= 1'b0;
            est <= 1'b0;
        end else begin
            if (done_ntf)                      ef <= 1'b1;
            else if (stat_wr && req_wdata[2])  ef <= 1'b0;
            if (bad_scope)                     est <= 1'b1;
            else if (stat_wr && req_wdata[1])  est <= 1'b0;
        end
    end

    always_comb begin
        case (rd_addr)
            OFS_PRIM:  rd_val = {28'd0, dr_code};
            OFS_MODE:  rd_val = mode_q;
            OFS_START: rd_val = start_q;
            OFS_SIZE:  rd_val = size_q;
            OFS_AMASK: rd_val = amask_q;
            OFS_WAYS:  rd_val = ways_q;
            OFS_SETC:  rd_val = {30'd0, fe[rd_id], oe[rd_id]};
            OFS_STAT:  rd_val = {29'd0, ef, est, ex_busy};
            default:   rd_val = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend   <= 1'b0;
            rd_id     <= '0;
            rd_addr   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_fire;
            if (rd_fire) begin
                rsp_rdata <= rd_val;
                rd_pend   <= 1'b0;
            end else if (rd_acc) begin
                rd_pend <= 1'b1;
                rd_id   <= req_id;
                rd_addr <= wa;
            end
        end
    end

    // R10
    prim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_pend && (rd_addr == OFS_PRIM) && dr_busy |=> !rsp_valid);

    // R7
    ef_set_chk: assert property (@(posedge clk) disable iff (rst)
        done_ntf |=> ef);

    // R8
    ef_clr_chk: assert property (@(posedge clk) disable iff (rst)
        stat_wr && req_wdata[2] && !done_ntf |=> !ef);

    // R11
    rsp_after_chk: assert property (@(posedge clk) disable iff (rst)
        rd_pend && (rd_addr != OFS_PRIM) |=> rsp_valid);

endmodule

// File: tb/cmq_frontend_tb.sv
`timescale 1ns/1ps
module cmq_frontend_tb;
    localparam int NM = 4;
    localparam int IDW = 2;
    localparam int AW = 12;
    localparam int LSH = 7;
    localparam int NSETS = 16;
    localparam int DRN = 6;

    localparam logic [11:0] A_PRIM = 12'h244, A_MODE = 12'h248, A_START = 12'h24C,
                            A_SIZE = 12'h250, A_WAYS = 12'h258,
                            A_SETC = 12'h25C, A_STAT = 12'h260;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_write;
    logic [IDW-1:0] req_id;
    logic [AW-1:0] req_addr;
    logic [31:0] req_wdata;
    logic req_ready, rsp_valid;
    logic [31:0] rsp_rdata;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmq_frontend #(.NM(NM), .IDW(IDW), .AW(AW), .LINE_SHIFT(LSH),
                   .NSETS(NSETS), .DRAIN_CYCLES(DRN)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int id, input logic [11:0] a, input logic [31:0] d,
                      output int wcyc);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_id = IDW'(id);
        req_addr = a; req_wdata = d;
        @(negedge clk);
        wcyc = cyc;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int id, input logic [11:0] a, output logic [31:0] d,
                      output int acyc, output int rcyc);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_id = IDW'(id); req_addr = a;
        @(negedge clk);
        acyc = cyc;
        req_valid = 1'b0;
        do @(negedge clk); while (!rsp_valid);
        rcyc = cyc;
        d = rsp_rdata;
    endtask

    // Poll status after a launch at edge l; command takes n cycles.
    task automatic poll(input int l, input int n, input bit ntf, input string req);
        logic [31:0] d;
        int a, r;
        bit busy_exp, ef_exp;
        for (int i = 0; i < 60; i++) begin
            rd(0, A_STAT, d, a, r);
            busy_exp = ((r - 1 - l) < n);
            ef_exp   = ntf && ((r - 1) >= (l + n + 1));
            check(d == {29'd0, ef_exp, 1'b0, busy_exp}, req, d, {29'd0, ef_exp, 1'b0, busy_exp});
            if (!busy_exp && (ef_exp || !ntf)) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d; int a, r;
        rd(0, A_STAT, d, a, r); check(d == 0, "R1 status", d, 0);
        rd(0, A_MODE, d, a, r); check(d == 0, "R1 mode", d, 0);
        check(r == a + 1, "R11 latency", r, a + 1);
        for (int m = 0; m < NM; m++) begin
            rd(m, A_SETC, d, a, r); check(d == 0, "R1 setc", d, 0);
        end
    endtask

    task automatic t_race();
        logic [31:0] d; int a, r, w;
        wr(0, A_MODE, 32'h0000_8002, w);
        wr(1, A_MODE, 32'h0002_0000, w);
        wr(1, A_START, 32'h0000_DEAD, w);
        wr(0, A_START, 32'h0000_1000, w);
        wr(0, A_SIZE, 32'h0000_0400, w);
        rd(3, A_START, d, a, r); check(d == 32'h1000, "R2 start kept", d, 32'h1000);
        rd(3, A_MODE, d, a, r); check(d == 32'h8002, "R2 mode kept", d, 32'h8002);
        rd(1, A_SETC, d, a, r); check(d == 1, "R2 loser OE", d, 1);
        rd(0, A_SETC, d, a, r); check(d == 0, "R4 winner", d, 0);
        poll(r, 8, 1'b1, "R5 R7 range 8 lines");
        wr(0, A_STAT, 32'h0, w);
        rd(0, A_STAT, d, a, r); check(d == 4, "R8 write 0 keeps EF", d, 4);
        wr(0, A_STAT, 32'h4, w);
        rd(0, A_STAT, d, a, r); check(d == 0, "R8 EF cleared", d, 0);
    endtask

    task automatic t_busy_reject();
        logic [31:0] d; int a, r, w, l;
        wr(1, A_MODE, 32'h0002_8000, w);
        rd(1, A_SETC, d, a, l); check(d == 0, "R4 released and reclaimed", d, 0);
        wr(2, A_MODE, 32'h0001_2345, w);
        rd(2, A_SETC, d, a, r); check(d == 2, "R3 FE", d, 2);
        rd(2, A_MODE, d, a, r); check(d == 32'h0002_8000, "R3 mode unchanged", d, 32'h0002_8000);
        poll(l, NSETS, 1'b1, "R6 whole cache");
        wr(0, A_STAT, 32'h4, w);
        wr(2, A_MODE, 32'h0000_8000, w);
        wr(2, A_START, 32'h0000_1040, w);
        wr(2, A_SIZE, 32'h0000_0080, w);
        rd(2, A_SETC, d, a, l); check(d == 0, "R3 retry clears flags", d, 0);
        poll(l, 2, 1'b1, "R5 unaligned 2 lines");
        wr(0, A_STAT, 32'h4, w);
    endtask

    task automatic t_ways_nonotify();
        logic [31:0] d; int a, r, w, l;
        wr(3, A_MODE, 32'h0044_8005, w);
        wr(3, A_WAYS, 32'h0000_000F, w);
        rd(3, A_SETC, d, a, l); check(d == 0, "R4 way launch", d, 0);
        poll(l, NSETS, 1'b1, "R6 way scope");
        wr(0, A_STAT, 32'h4, w);
        wr(0, A_MODE, 32'h0000_0001, w);
        wr(0, A_START, 32'h0, w);
        wr(0, A_SIZE, 32'h0, w);
        rd(0, A_SETC, d, a, l);
        poll(l, 1, 1'b0, "R5 R7 zero size no notify");
        rd(0, A_STAT, d, a, r); check(d == 0, "R7 no EF", d, 0);
    endtask

    task automatic t_bad_scope();
        logic [31:0] d; int a, r, w;
        wr(1, A_MODE, 32'h0006_8000, w);
        rd(1, A_SETC, d, a, r);
        rd(1, A_STAT, d, a, r); check(d == 2, "R9 EST no busy", d, 2);
        wr(1, A_STAT, 32'h2, w);
        rd(1, A_STAT, d, a, r); check(d == 0, "R8 EST cleared", d, 0);
    endtask

    task automatic t_prim();
        logic [31:0] d; int a, r, w;
        wr(0, A_PRIM, 32'h8, w);
        rd(0, A_PRIM, d, a, r);
        check(r == w + DRN + 1, "R10 drain stall", r, w + DRN + 1);
        check(d == 8, "R10 code", d, 8);
        wr(0, A_PRIM, 32'h3, w);
        rd(0, A_PRIM, d, a, r);
        check(d == 8 && r == a + 1, "R10 other code ignored", d, 8);
        wr(1, A_PRIM, 32'h9, w);
        rd(1, A_PRIM, d, a, r);
        check(d == 9 && r == w + DRN + 1, "R10 pf flush", d, 9);
    endtask

    initial begin
        req_valid = 1'b0; req_write = 1'b0; req_id = '0;
        req_addr = '0; req_wdata = '0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_race();
        t_busy_reject();
        t_ways_nonotify();
        t_bad_scope();
        t_prim();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule